// File: doc/BRIEF.md
# Spin-Lock Requester with Backoff

This block sits beside one processor and obtains a shared lock word on that processor's behalf. When the processor asks for the lock, the block polls the lock word with plain reads for as long as the word reads taken. Once a read comes back free, it waits a backoff delay and then issues a single atomic test-and-set. A test-and-set that finds the word free wins the lock. One that finds it taken sends the block back to polling. The block reports ownership on a status pin. A release command makes it write the free value back to the lock word.

The backoff delay has two modes. In the static mode each processor waits a fixed slot that grows with its identifier, so lower identifiers get priority. In the dynamic mode the wait is a pseudo-random value inside a window that doubles after every failed test-and-set. The window stops growing at a programmable cap and shrinks back to its base size after a successful acquisition. The block can optionally insert a fixed pause after every read that finds the lock taken, which lowers the polling rate.

The memory side is a valid/ready request channel paired with a valid/ready response channel. Only one request is ever outstanding, and every request gets exactly one response. The block counts the test-and-set attempts made for the current acquisition.

Top module: `spin_requester`

## Requirements
- R1: While reset is active, and on the first cycle after it, `req_valid`, `rsp_ready` and `acquired` are low and `attempts` is zero.
- R2: When a read (op code 2'b00) returns 1 (the lock is taken), the next request is another read, never a test-and-set.
- R3: With `poll_gap_en` low, the read that follows a taken read is presented starting at the same clock edge that accepted the response (N=0). With `poll_gap_en` high, that read starts N=POLL_GAP+1 edges after that edge.
- R4: In static mode (`dyn_mode` low), after a read returns 0 (free), the test-and-set request (op code 2'b01) starts exactly N=(cpu_id+1)*SLOT_CYC+1 edges after the edge that accepted that response.
- R5: A test-and-set that returns 1 is followed by a read starting at the edge that accepted its response (N=0).
- R6: A test-and-set that returns 0 raises `acquired` from the edge that accepted that response. No further request is issued while `acquired` is high.
- R7: In dynamic mode the test-and-set starts N=D+1 edges after the free read, where D lies in [0, 2^e-1] and e = min(x, cap_exp). The exponent x is BASE_EXP after reset. Each failed test-and-set raises x by one, up to the cap, and a successful acquisition returns x to BASE_EXP.
- R8: A `rel_cmd` while `acquired` is high drops `acquired` from the next edge. The block then issues exactly one write (op code 2'b10) with `req_wdata` 0 (free) and returns to idle after its response.
- R9: `rel_cmd` has no effect while `acquired` is low: no request is issued.
- R10: `acq_cmd` has no effect unless the block is idle: while the lock is held it causes no request and leaves `acquired` and `attempts` unchanged.
- R11: `attempts` clears when an acquire command is accepted and rises by one on each accepted test-and-set request, saturating at its maximum.
- R12: Once `req_valid` is high, it stays high with a stable op, address and write data until `req_ready` is seen. `rsp_ready` is high only while a response is awaited, never at the same time as `req_valid`, and `rsp_valid` is ignored at other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_cmd | input | 1 | One-cycle request to obtain the lock |
| rel_cmd | input | 1 | One-cycle request to give up the lock |
| cpu_id | input | ID_W | Identifier of the owning processor; selects the static slot |
| dyn_mode | input | 1 | 1 selects the exponential pseudo-random backoff |
| poll_gap_en | input | 1 | 1 inserts a pause after each read that finds the lock taken |
| cap_exp | input | EXP_W | Upper bound on the dynamic window exponent |
| lock_addr | input | ADDR_W | Address of the lock word |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_op | output | 2 | 00 read, 01 test-and-set, 10 write |
| req_addr | output | ADDR_W | Request address |
| req_wdata | output | 1 | Write value (always the free value 0) |
| rsp_valid | input | 1 | Memory response valid |
| rsp_ready | output | 1 | Block is waiting for a response |
| rsp_data | input | 1 | Old lock value: 1 taken, 0 free |
| acquired | output | 1 | The lock is held |
| attempts | output | CNT_W | Test-and-set requests made for the current acquisition |

## Verification
The hardest case to reach is a test-and-set that fails even though the read just before it found the lock free: another processor has to seize the word during the backoff. The bench's memory model has a steal counter for this. While the counter is non-zero, it answers test-and-set with taken and then keeps the word taken for a few more reads. This drives the block through repeated failures, so the return to read polling, the attempt count and the dynamic window growth can all be observed. The dynamic waits are pseudo-random, so the bench checks them against window bounds. It also uses a zero cap to force one exact timing.

// File: rtl/spin_pkg.sv
package spin_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_TAS   = 2'b01,
    OP_WRITE = 2'b10
  } mem_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_SPIN,
    ST_BACKOFF,
    ST_TSL,
    ST_HELD,
    ST_RELEASE
  } ctl_state_e;

  // sub-step inside the states that talk to memory
  typedef enum logic [1:0] {
    PH_ISSUE,
    PH_WAIT,
    PH_GAP
  } phase_e;

  localparam logic LOCK_FREE  = 1'b0;
  localparam logic LOCK_TAKEN = 1'b1;

endpackage

// File: rtl/spin_lfsr.sv
module spin_lfsr #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  TAPS = 16'hB400,
  parameter logic [W-1:0]  SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);

  logic [W-1:0] q;

  // Galois form, shifts right every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= SEED;
    end else begin
      q <= (q >> 1) ^ (q[0] ? TAPS : '0);
    end
  end

  assign value = q;

endmodule

// File: rtl/spin_window.sv
module spin_window #(
  parameter int MAX_EXP  = 10,
  parameter int BASE_EXP = 1,
  parameter int DLY_W    = 16,
  localparam int EXP_W   = $clog2(MAX_EXP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grow,
  input  logic             restart,
  input  logic [EXP_W-1:0] cap,
  output logic [DLY_W-1:0] mask
);

  localparam logic [EXP_W-1:0] BASE_V = EXP_W'(BASE_EXP);
  localparam logic [EXP_W-1:0] MAX_V  = EXP_W'(MAX_EXP);

  logic [EXP_W-1:0] exp_q;
  logic [EXP_W-1:0] cap_eff;
  logic [EXP_W-1:0] exp_eff;

  assign cap_eff = (cap > MAX_V) ? MAX_V : cap;
  assign exp_eff = (exp_q > cap_eff) ? cap_eff : exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= BASE_V;
    end else if (restart) begin
      exp_q <= BASE_V;
    end else if (grow) begin
      exp_q <= (exp_eff < cap_eff) ? exp_eff + 1'b1 : cap_eff;
    end
  end

  // window mask: the low exp_eff bits set
  for (genvar g = 0; g < DLY_W; g++) begin : g_mask
    assign mask[g] = (32'(exp_eff) > g);
  end

endmodule

// File: rtl/spin_timer.sv
module spin_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/spin_requester.sv
module spin_requester
  import spin_pkg::*;
#(
  parameter int ID_W     = 3,
  parameter int ADDR_W   = 32,
  parameter int DLY_W    = 16,
  parameter int SLOT_CYC = 4,
  parameter int POLL_GAP = 3,
  parameter int MAX_EXP  = 10,
  parameter int BASE_EXP = 1,
  parameter int CNT_W    = 8,
  parameter logic [DLY_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [DLY_W-1:0] LFSR_SEED = 16'hACE1,
  localparam int EXP_W   = $clog2(MAX_EXP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_cmd,
  input  logic              rel_cmd,
  input  logic [ID_W-1:0]   cpu_id,
  input  logic              dyn_mode,
  input  logic              poll_gap_en,
  input  logic [EXP_W-1:0]  cap_exp,
  input  logic [ADDR_W-1:0] lock_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [1:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic              req_wdata,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic              rsp_data,
  output logic              acquired,
  output logic [CNT_W-1:0]  attempts
);

  localparam logic [DLY_W-1:0] POLL_VAL = DLY_W'(POLL_GAP);

  ctl_state_e st_q, st_d;
  phase_e     ph_q, ph_d;

  logic             tmr_load;
  logic [DLY_W-1:0] tmr_val;
  logic             tmr_done;
  logic             win_grow;
  logic             win_restart;
  logic [DLY_W-1:0] win_mask;
  logic [DLY_W-1:0] rnd;
  logic [DLY_W-1:0] static_dly;
  logic [DLY_W-1:0] dyn_dly;
  logic [DLY_W-1:0] dly_pick;
  logic             att_clr;
  logic             att_inc;
  logic             mem_state;

  // ---------------- delay sources ----------------
  spin_lfsr #(
    .W    (DLY_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd)
  );

  spin_window #(
    .MAX_EXP  (MAX_EXP),
    .BASE_EXP (BASE_EXP),
    .DLY_W    (DLY_W)
  ) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .grow    (win_grow),
    .restart (win_restart),
    .cap     (cap_exp),
    .mask    (win_mask)
  );

  spin_timer #(
    .W (DLY_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  // lower identifiers get shorter slots
  assign static_dly = DLY_W'((32'(cpu_id) + 1) * SLOT_CYC);
  // identifier folded in so that peers draw different values
  assign dyn_dly    = (rnd ^ DLY_W'(cpu_id)) & win_mask;
  assign dly_pick   = dyn_mode ? dyn_dly : static_dly;

  // ---------------- control ----------------
  always_comb begin
    st_d        = st_q;
    ph_d        = ph_q;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    win_grow    = 1'b0;
    win_restart = 1'b0;
    att_clr     = 1'b0;
    att_inc     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (acq_cmd) begin
          st_d    = ST_READ_SPIN;
          ph_d    = PH_ISSUE;
          att_clr = 1'b1;
        end
      end
      ST_READ_SPIN: begin
        case (ph_q)
          PH_ISSUE: if (req_ready) ph_d = PH_WAIT;
          PH_WAIT: begin
            if (rsp_valid) begin
              if (rsp_data == LOCK_TAKEN) begin
                if (poll_gap_en) begin
                  ph_d     = PH_GAP;
                  tmr_load = 1'b1;
                  tmr_val  = POLL_VAL;
                end else begin
                  ph_d = PH_ISSUE;
                end
              end else begin
                st_d     = ST_BACKOFF;
                ph_d     = PH_ISSUE;
                tmr_load = 1'b1;
                tmr_val  = dly_pick;
              end
            end
          end
          default: if (tmr_done) ph_d = PH_ISSUE;
        endcase
      end
      ST_BACKOFF: begin
        if (tmr_done) begin
          st_d = ST_TSL;
          ph_d = PH_ISSUE;
        end
      end
      ST_TSL: begin
        if (ph_q == PH_ISSUE) begin
          if (req_ready) begin
            ph_d    = PH_WAIT;
            att_inc = 1'b1;
          end
        end else if (rsp_valid) begin
          ph_d = PH_ISSUE;
          if (rsp_data == LOCK_TAKEN) begin
            st_d     = ST_READ_SPIN;
            win_grow = 1'b1;
          end else begin
            st_d        = ST_HELD;
            win_restart = 1'b1;
          end
        end
      end
      ST_HELD: begin
        if (rel_cmd) begin
          st_d = ST_RELEASE;
          ph_d = PH_ISSUE;
        end
      end
      ST_RELEASE: begin
        if (ph_q == PH_ISSUE) begin
          if (req_ready) ph_d = PH_WAIT;
        end else if (rsp_valid) begin
          st_d = ST_IDLE;
          ph_d = PH_ISSUE;
        end
      end
      default: begin
        st_d = ST_IDLE;
        ph_d = PH_ISSUE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      ph_q <= PH_ISSUE;
    end else begin
      st_q <= st_d;
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attempts <= '0;
    end else if (att_clr) begin
      attempts <= '0;
    end else if (att_inc && (attempts != '1)) begin
      attempts <= attempts + 1'b1;
    end
  end

  // ---------------- memory channel ----------------
  assign mem_state = (st_q == ST_READ_SPIN) || (st_q == ST_TSL) ||
                     (st_q == ST_RELEASE);
  assign req_valid = mem_state && (ph_q == PH_ISSUE);
  assign rsp_ready = mem_state && (ph_q == PH_WAIT);

  always_comb begin
    case (st_q)
      ST_TSL:     req_op = OP_TAS;
      ST_RELEASE: req_op = OP_WRITE;
      default:    req_op = OP_READ;
    endcase
  end

  assign req_addr  = lock_addr;
  assign req_wdata = LOCK_FREE;
  assign acquired  = (st_q == ST_HELD);

endmodule

// File: rtl/spin_requester_chk.sv
module spin_requester_chk
  import spin_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rel_cmd,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_data,
  input logic              acquired,
  input logic [CNT_W-1:0]  attempts
);

  logic [1:0] out_op;
  logic       last_rd_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_op       <= OP_READ;
      last_rd_busy <= 1'b0;
    end else begin
      if (req_valid && req_ready) out_op <= req_op;
      if (rsp_valid && rsp_ready)
        last_rd_busy <= (out_op == OP_READ) && (rsp_data == LOCK_TAKEN);
    end
  end

  // R12
  hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_op) &&
                                   $stable(req_addr) && $stable(req_wdata)));

  // R12
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_ready));

  // R2
  no_tas_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_TAS) |-> !last_rd_busy);

  // R6
  own_after_free_tas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acquired) |-> $past(rsp_valid && rsp_ready && rsp_data == LOCK_FREE &&
                              out_op == OP_TAS));

  // R6
  quiet_while_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acquired |-> !req_valid);

  // R8
  drop_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acquired) |-> $past(rel_cmd));

  // R9
  write_from_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_valid) && req_op == OP_WRITE) |-> $past(acquired));

  // R11
  attempts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempts != $past(attempts)) |->
      ((attempts == '0) ||
       ((attempts == $past(attempts) + 1'b1) &&
        $past(req_valid && req_ready && req_op == OP_TAS))));

endmodule

bind spin_requester spin_requester_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rel_cmd   (rel_cmd),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .acquired  (acquired),
  .attempts  (attempts)
);

// File: tb/test_spin_requester.sv
module test_spin_requester;

  localparam int CLK_PERIOD = 10;
  localparam int ID_W  = 3;
  localparam int SLOT  = 4;
  localparam int GAP   = 3;
  localparam int BASE  = 1;
  localparam int EXP_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acq_cmd = 1'b0;
  logic             rel_cmd = 1'b0;
  logic [ID_W-1:0]  cpu_id = '0;
  logic             dyn_mode = 1'b0;
  logic             poll_gap_en = 1'b0;
  logic [EXP_W-1:0] cap_exp = 4'd10;
  logic [31:0]      lock_addr = 32'h0000_4400;
  logic             req_valid;
  logic             req_ready = 1'b1;
  logic [1:0]       req_op;
  logic [31:0]      req_addr;
  logic             req_wdata;
  logic             rsp_valid = 1'b0;
  logic             rsp_ready;
  logic             rsp_data = 1'b0;
  logic             acquired;
  logic [7:0]       attempts;

  spin_requester #(
    .ID_W     (ID_W),
    .SLOT_CYC (SLOT),
    .POLL_GAP (GAP),
    .BASE_EXP (BASE)
  ) i_spin_requester (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_cmd     (acq_cmd),
    .rel_cmd     (rel_cmd),
    .cpu_id      (cpu_id),
    .dyn_mode    (dyn_mode),
    .poll_gap_en (poll_gap_en),
    .cap_exp     (cap_exp),
    .lock_addr   (lock_addr),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .acquired    (acquired),
    .attempts    (attempts)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // memory model and monitor state
  bit lock_val = 1'b0;
  int busy_reads = 0;
  int steal = 0;
  int stall_cfg = 0;
  int stall_left = 0;
  bit pend = 1'b0, pend_data = 1'b0, have_new = 1'b0, new_data = 1'b0;
  logic [1:0] out_op = 2'b00;
  bit prev_rv = 1'b0, prev_rdy = 1'b1;
  logic [1:0] prev_op = 2'b00;
  int last_rsp_edge = 0;
  bit last_rd_busy = 1'b0, last_tsl_fail = 1'b0;
  int n_req = 0, n_write = 0, bad_tsl = 0, unstable = 0;
  bit last_wdata = 1'b1;
  int tsl_gap [32];
  int n_tg = 0;
  int rd_gap [32];
  int n_rg = 0;
  int fail_gap [32];
  logic [1:0] fail_op [32];
  int n_fg = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_log();
    n_tg = 0; n_rg = 0; n_fg = 0; bad_tsl = 0; unstable = 0;
  endtask

  initial forever begin
    @(posedge clk);
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // memory model: driven at the falling edge, values stay put until the next one
  initial forever begin
    @(negedge clk);
    if (have_new) begin pend = 1'b1; pend_data = new_data; have_new = 1'b0; end
    if (req_valid && !prev_rv) begin
      int g;
      g = cyc - last_rsp_edge;
      n_req++;
      if (req_op == 2'b01) begin
        if (n_tg < 32) tsl_gap[n_tg] = g;
        n_tg++;
        if (last_rd_busy) bad_tsl++;
      end else if (req_op == 2'b00 && last_rd_busy) begin
        if (n_rg < 32) rd_gap[n_rg] = g;
        n_rg++;
      end
      if (last_tsl_fail) begin
        if (n_fg < 32) begin fail_gap[n_fg] = g; fail_op[n_fg] = req_op; end
        n_fg++;
        last_tsl_fail = 1'b0;
      end
      stall_left = stall_cfg;
    end
    if (prev_rv && !prev_rdy && (!req_valid || req_op != prev_op)) unstable++;
    req_ready = (stall_left == 0);
    rsp_valid = pend;
    rsp_data  = pend_data;
    if (rsp_valid && rsp_ready) begin
      last_rsp_edge = cyc + 1;
      last_rd_busy  = (out_op == 2'b00) && pend_data;
      last_tsl_fail = (out_op == 2'b01) && pend_data;
      pend = 1'b0;
    end
    if (req_valid && req_ready) begin
      out_op   = req_op;
      have_new = 1'b1;
      case (req_op)
        2'b00: begin
          new_data = lock_val;
          if (lock_val && busy_reads > 0) begin
            busy_reads--;
            if (busy_reads == 0) lock_val = 1'b0;
          end
        end
        2'b01: begin
          if (steal > 0) begin
            steal--; new_data = 1'b1; lock_val = 1'b1; busy_reads = 2;
          end else begin
            new_data = lock_val; lock_val = 1'b1;
          end
        end
        default: begin
          new_data = 1'b0; lock_val = req_wdata; last_wdata = req_wdata; n_write++;
        end
      endcase
    end else if (req_valid) begin
      stall_left--;
    end
    prev_rv = req_valid; prev_op = req_op; prev_rdy = req_ready;
  end

  task automatic pulse_acq();
    @(negedge clk); acq_cmd = 1'b1;
    @(negedge clk); acq_cmd = 1'b0;
  endtask

  task automatic wait_acquired(input string req);
    int k = 0;
    while (!acquired && k < 3000) begin @(negedge clk); k++; end
    chk(acquired == 1'b1, req, acquired, 1);
  endtask

  // R8: release path
  task automatic do_release();
    int w0 = n_write;
    @(negedge clk); rel_cmd = 1'b1;
    @(negedge clk); rel_cmd = 1'b0;
    chk(acquired == 1'b0, "R8 acquired after release", acquired, 0);
    chk(req_valid && req_op == 2'b10, "R8 write presented", req_op, 2);
    repeat (12) @(negedge clk);
    chk(n_write == w0 + 1, "R8 one write", n_write - w0, 1);
    chk(last_wdata == 1'b0, "R8 write value free", last_wdata, 0);
    chk(!req_valid && !rsp_ready, "R8 back to idle", req_valid, 0);
  endtask

  task automatic t_reset();
    chk(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
    chk(rsp_ready == 1'b0, "R1 rsp_ready", rsp_ready, 0);
    chk(acquired == 1'b0, "R1 acquired", acquired, 0);
    chk(attempts == 8'd0, "R1 attempts", attempts, 0);
  endtask

  task automatic t_static_free();
    clear_log();
    cpu_id = 3'd2; dyn_mode = 1'b0; lock_val = 1'b0;
    pulse_acq();
    wait_acquired("R6 static acquire");
    chk(n_tg == 1 && tsl_gap[0] == 3 * SLOT + 1, "R4 static slot id2", tsl_gap[0], 3 * SLOT + 1);
    chk(attempts == 8'd1, "R11 one attempt", attempts, 1);
    begin
      int r0 = n_req;
      repeat (8) @(negedge clk);
      chk(n_req == r0 && acquired, "R6 quiet while held", n_req - r0, 0);
    end
    do_release();
  endtask

  task automatic t_spin_busy();
    clear_log();
    cpu_id = 3'd0; poll_gap_en = 1'b0; lock_val = 1'b1; busy_reads = 5;
    pulse_acq();
    wait_acquired("R2 acquire after spin");
    chk(bad_tsl == 0, "R2 no test-and-set on busy", bad_tsl, 0);
    chk(n_rg == 5, "R2 reads after busy", n_rg, 5);
    for (int i = 0; i < 5; i++) chk(rd_gap[i] == 0, "R3 back-to-back read", rd_gap[i], 0);
    chk(tsl_gap[0] == SLOT + 1, "R4 static slot id0", tsl_gap[0], SLOT + 1);
    do_release();
  endtask

  task automatic t_poll_gap();
    clear_log();
    cpu_id = 3'd0; poll_gap_en = 1'b1; lock_val = 1'b1; busy_reads = 4;
    pulse_acq();
    wait_acquired("R3 acquire with gap");
    chk(n_rg == 4, "R3 gap reads", n_rg, 4);
    for (int i = 0; i < 4; i++) chk(rd_gap[i] == GAP + 1, "R3 paced read", rd_gap[i], GAP + 1);
    poll_gap_en = 1'b0;
    do_release();
  endtask

  task automatic t_tsl_fail();
    clear_log();
    cpu_id = 3'd0; lock_val = 1'b0; steal = 2;
    pulse_acq();
    wait_acquired("R5 acquire after failures");
    chk(n_fg == 2, "R5 failures seen", n_fg, 2);
    for (int i = 0; i < 2; i++) begin
      chk(fail_op[i] == 2'b00, "R5 read after failed tas", fail_op[i], 0);
      chk(fail_gap[i] == 0, "R5 immediate read", fail_gap[i], 0);
    end
    chk(attempts == 8'd3, "R11 three attempts", attempts, 3);
    chk(bad_tsl == 0, "R2 no tas on busy read", bad_tsl, 0);
    do_release();
    clear_log();
    pulse_acq();
    wait_acquired("R11 reacquire");
    chk(attempts == 8'd1, "R11 cleared on acquire", attempts, 1);
    do_release();
  endtask

  task automatic t_dyn_cap0();
    clear_log();
    dyn_mode = 1'b1; cap_exp = 4'd0; lock_val = 1'b0; steal = 3;
    pulse_acq();
    wait_acquired("R7 acquire cap0");
    chk(n_tg == 4, "R7 tas count cap0", n_tg, 4);
    for (int i = 0; i < 4; i++) chk(tsl_gap[i] == 1, "R7 zero window", tsl_gap[i], 1);
    do_release();
  endtask

  task automatic t_dyn_cap2();
    clear_log();
    dyn_mode = 1'b1; cap_exp = 4'd2; lock_val = 1'b0; steal = 6;
    pulse_acq();
    wait_acquired("R7 acquire cap2");
    chk(n_tg == 7, "R7 tas count cap2", n_tg, 7);
    chk(tsl_gap[0] <= 2, "R7 base window", tsl_gap[0], 2);
    for (int i = 0; i < 7; i++) chk(tsl_gap[i] >= 1 && tsl_gap[i] <= 4, "R7 capped window", tsl_gap[i], 4);
    do_release();
    clear_log();
    pulse_acq();
    wait_acquired("R7 reacquire");
    chk(n_tg == 1 && tsl_gap[0] <= 2, "R7 window restarted", tsl_gap[0], 2);
    do_release();
    dyn_mode = 1'b0; cap_exp = 4'd10;
  endtask

  task automatic t_release_ignored();
    int r0 = n_req;
    @(negedge clk); rel_cmd = 1'b1;
    @(negedge clk); rel_cmd = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_req == r0, "R9 release in idle", n_req - r0, 0);
    chk(acquired == 1'b0, "R9 still not held", acquired, 0);
  endtask

  task automatic t_acquire_ignored();
    int r0;
    logic [7:0] a0;
    lock_val = 1'b0;
    pulse_acq();
    wait_acquired("R10 setup");
    r0 = n_req; a0 = attempts;
    pulse_acq();
    repeat (10) @(negedge clk);
    chk(n_req == r0, "R10 acquire while held", n_req - r0, 0);
    chk(acquired == 1'b1, "R10 still held", acquired, 1);
    chk(attempts == a0, "R10 attempts kept", attempts, a0);
    do_release();
  endtask

  task automatic t_backpressure();
    clear_log();
    cpu_id = 3'd1; stall_cfg = 3; lock_val = 1'b1; busy_reads = 2;
    pulse_acq();
    wait_acquired("R12 acquire under stall");
    chk(unstable == 0, "R12 request held stable", unstable, 0);
    chk(tsl_gap[0] == 2 * SLOT + 1, "R4 slot under stall", tsl_gap[0], 2 * SLOT + 1);
    chk(req_addr == lock_addr, "R12 address", req_addr, lock_addr);
    do_release();
    chk(unstable == 0, "R12 write held stable", unstable, 0);
    stall_cfg = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    repeat (2) @(negedge clk);
    t_release_ignored();
    t_static_free();
    t_spin_busy();
    t_poll_gap();
    t_tsl_fail();
    t_dyn_cap0();
    t_dyn_cap2();
    t_acquire_ignored();
    t_backpressure();
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule